// File: doc/BRIEF.md
# Register Rename Map with Squash Recovery

This block translates architectural register numbers into physical register numbers for an out-of-order core that renames one instruction per cycle. The map is kept as a content-addressed table. Each physical register carries the architectural number it stands for and a bit that marks it as the current holder of that name. A source is resolved by matching its architectural number against every entry. Each instruction that writes a register takes a fresh physical register from a bitmap free list, and it reports the register that held the previous value of its destination.

Each rename takes a slot in a 16-entry circular in-flight window. The slot index is returned as the instruction's age tag. With the slot, the block stores a snapshot of the current-holder bits as they were before the rename. Retirement takes the oldest slot and returns its stale register to the free list. A squash names the tag of the oldest instruction to discard. In a single cycle the block restores that instruction's snapshot, empties the window from that slot onward, and frees every register the discarded instructions had allocated.

Top module: `rename_map_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i, physical registers 32 to 63 are free, the window is empty and ren_ready is high.
- R2: ren_src0_phys and ren_src1_phys give the current mapping of their architectural inputs in the same cycle, combinationally. When a source names the instruction's own destination, it sees the mapping from before that instruction.
- R3: A rename with ren_has_dst set gets the lowest-numbered free physical register on ren_dst_phys. From the next cycle, later lookups of that architectural register return it, and the register is no longer free.
- R4: ren_stale_phys gives the mapping of ren_dst_arch from before the rename. It stays allocated until that instruction retires.
- R5: ren_tag gives the window slot the instruction takes. Tags count up by one modulo 16 for each accepted rename.
- R6: ren_ready is low while 16 instructions are in flight or sq_valid is high. A request made while ren_ready is low changes nothing.
- R7: A retire pulse with a non-empty window removes the oldest instruction and frees its stale register, if it has one. A retire with an empty window is ignored. A rename and a retire in the same cycle both take effect.
- R8: A squash whose sq_tag is in flight restores the map to the state it had just before that instruction was renamed, and removes it and every younger instruction. The next accepted rename reuses that tag.
- R9: Physical registers allocated by squashed instructions are free from the cycle after the squash.
- R10: A squash whose tag is not in flight leaves all state unchanged. A retire pulse in a cycle with sq_valid high is ignored.
- R11: A rename with ren_has_dst low takes a slot and a tag but allocates nothing and leaves the map unchanged. Its retirement frees nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename request |
| ren_ready | output | 1 | Rename can be accepted this cycle |
| ren_has_dst | input | 1 | Instruction writes a register |
| ren_dst_arch | input | 5 | Architectural destination |
| ren_src0_arch | input | 5 | Architectural source 0 |
| ren_src1_arch | input | 5 | Architectural source 1 |
| ren_src0_phys | output | 6 | Physical register for source 0 |
| ren_src1_phys | output | 6 | Physical register for source 1 |
| ren_dst_phys | output | 6 | Newly allocated destination register (meaningful with ren_has_dst) |
| ren_stale_phys | output | 6 | Previous holder of the destination name |
| ren_tag | output | 4 | Age tag (window slot) of the instruction |
| ret_valid | input | 1 | Retire the oldest in-flight instruction |
| sq_valid | input | 1 | Squash request |
| sq_tag | input | 4 | Tag of the oldest instruction to discard |

## Verification
All rename results (ready, source and destination registers, stale register, tag) are combinational and due in the same cycle as the request. Map, free-list and window changes from a rename, retire or squash show up one cycle later, after the next rising edge. The bench drives inputs on the falling edge and compares outputs 1 ns later against a behavioural model. That model is advanced only after each rising edge, so every comparison sees exactly the state the preceding edges produced. Ignored retires and squashes are judged through later lookups and allocations, which the model predicts from unchanged state.

// File: rtl/rmu_pkg.sv
package rmu_pkg;
  localparam int unsigned ARCH_REGS = 32;
  localparam int unsigned PHYS_REGS = 64;
  localparam int unsigned WIN_SLOTS = 16;  // power of two
endpackage

// File: rtl/rmu_map.sv
module rmu_map #(
  parameter int unsigned NARCH = rmu_pkg::ARCH_REGS,
  parameter int unsigned NPHYS = rmu_pkg::PHYS_REGS,
  parameter int unsigned NWIN  = rmu_pkg::WIN_SLOTS,
  localparam int unsigned AW = $clog2(NARCH),
  localparam int unsigned PW = $clog2(NPHYS),
  localparam int unsigned WW = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] look0_arch,
  input  logic [AW-1:0] look1_arch,
  input  logic [AW-1:0] lookd_arch,
  output logic [PW-1:0] look0_phys,
  output logic [PW-1:0] look1_phys,
  output logic [PW-1:0] lookd_phys,
  input  logic          bind_en,
  input  logic [AW-1:0] bind_arch,
  input  logic [PW-1:0] bind_phys,
  input  logic          save_en,
  input  logic [WW-1:0] save_slot,
  input  logic          restore_en,
  input  logic [WW-1:0] restore_slot
);
  localparam logic [NPHYS-1:0] CUR_RST = {{(NPHYS-NARCH){1'b0}}, {NARCH{1'b1}}};

  logic [AW-1:0]    name_q [NPHYS];
  logic [AW-1:0]    name_d [NPHYS];
  logic [NPHYS-1:0] cur_q, cur_d;
  logic [NPHYS-1:0] ckpt_q [NWIN];
  logic [NPHYS-1:0] hit0, hit1, hitd;

  for (genvar i = 0; i < NPHYS; i++) begin : g_cam
    assign hit0[i] = cur_q[i] && (name_q[i] == look0_arch);
    assign hit1[i] = cur_q[i] && (name_q[i] == look1_arch);
    assign hitd[i] = cur_q[i] && (name_q[i] == lookd_arch);
  end

  always_comb begin
    look0_phys = '0;
    look1_phys = '0;
    lookd_phys = '0;
    for (int i = 0; i < NPHYS; i++) begin
      if (hit0[i]) look0_phys = look0_phys | PW'(i);
      if (hit1[i]) look1_phys = look1_phys | PW'(i);
      if (hitd[i]) lookd_phys = lookd_phys | PW'(i);
    end
  end

  always_comb begin
    cur_d  = cur_q;
    name_d = name_q;
    if (restore_en) begin
      cur_d = ckpt_q[restore_slot];
    end else if (bind_en) begin
      cur_d            = cur_q & ~hitd;
      cur_d[bind_phys] = 1'b1;
      name_d[bind_phys] = bind_arch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= CUR_RST;
      for (int i = 0; i < NPHYS; i++) name_q[i] <= (i < NARCH) ? AW'(i) : '0;
    end else begin
      cur_q  <= cur_d;
      name_q <= name_d;
    end
  end

  always_ff @(posedge clk) begin
    if (save_en) ckpt_q[save_slot] <= cur_q;
  end

  AST_CAM_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit0) == 1); // R2
  AST_BIND_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bind_en && !restore_en) |=> cur_q[$past(bind_phys)]); // R3
endmodule

// File: rtl/rmu_free_list.sv
module rmu_free_list #(
  parameter int unsigned NARCH = rmu_pkg::ARCH_REGS,
  parameter int unsigned NPHYS = rmu_pkg::PHYS_REGS,
  localparam int unsigned PW = $clog2(NPHYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_en,
  output logic [PW-1:0]    take_phys,
  output logic             any_free,
  input  logic             give_en,
  input  logic [PW-1:0]    give_phys,
  input  logic [NPHYS-1:0] give_mask
);
  localparam logic [NPHYS-1:0] POOL_RST = {{(NPHYS-NARCH){1'b1}}, {NARCH{1'b0}}};

  logic [NPHYS-1:0] pool_q, pool_d;

  always_comb begin
    take_phys = '0;
    for (int i = NPHYS - 1; i >= 0; i--) begin
      if (pool_q[i]) take_phys = PW'(i);
    end
  end

  assign any_free = |pool_q;

  always_comb begin
    pool_d = pool_q;
    if (take_en) pool_d[take_phys] = 1'b0;
    if (give_en) pool_d[give_phys] = 1'b1;
    pool_d = pool_d | give_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pool_q <= POOL_RST;
    else        pool_q <= pool_d;
  end

  AST_TAKE_LEAVES_POOL: assert property (@(posedge clk) disable iff (!rst_n)
    take_en |=> !pool_q[$past(take_phys)]); // R3
  AST_RETIRE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    give_en |=> pool_q[$past(give_phys)]); // R7
  AST_SQUASH_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (|give_mask) |=> ((pool_q & $past(give_mask)) == $past(give_mask))); // R9
endmodule

// File: rtl/rmu_window.sv
module rmu_window #(
  parameter int unsigned NPHYS = rmu_pkg::PHYS_REGS,
  parameter int unsigned NWIN  = rmu_pkg::WIN_SLOTS,
  localparam int unsigned PW = $clog2(NPHYS),
  localparam int unsigned WW = $clog2(NWIN),
  localparam int unsigned CW = WW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             push_wr,
  input  logic [PW-1:0]    push_new,
  input  logic [PW-1:0]    push_old,
  input  logic             pop,
  input  logic             cut_req,
  input  logic [WW-1:0]    cut_tag,
  output logic [WW-1:0]    tail_slot,
  output logic             full,
  output logic             empty,
  output logic             cut_hit,
  output logic             head_wr,
  output logic [PW-1:0]    head_old,
  output logic [NPHYS-1:0] cut_mask
);
  logic [WW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_q  [NWIN];
  logic [PW-1:0] new_q [NWIN];
  logic [PW-1:0] old_q [NWIN];
  logic [WW-1:0] cut_off;

  assign tail_slot = tail_q;
  assign full      = (cnt_q == CW'(NWIN));
  assign empty     = (cnt_q == '0);
  assign head_wr   = wr_q[head_q];
  assign head_old  = old_q[head_q];
  assign cut_off   = cut_tag - head_q;
  assign cut_hit   = cut_req && ({1'b0, cut_off} < cnt_q);

  always_comb begin
    cut_mask = '0;
    for (int e = 0; e < NWIN; e++) begin
      logic [WW-1:0] off;
      off = WW'(e) - head_q;
      if (cut_hit && (off >= cut_off) && ({1'b0, off} < cnt_q) && wr_q[e])
        cut_mask[new_q[e]] = 1'b1;
    end
  end

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (cut_hit) begin
      tail_d = cut_tag;
      cnt_d  = {1'b0, cut_off};
    end else begin
      if (push) tail_d = tail_q + 1'b1;
      if (pop)  head_d = head_q + 1'b1;
      cnt_d = cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !cut_hit) begin
      wr_q[tail_q]  <= push_wr;
      new_q[tail_q] <= push_new;
      old_q[tail_q] <= push_old;
    end
  end

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push); // R6
  AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !cut_hit) |=> tail_q == WW'($past(tail_q) + 1'b1)); // R5
  AST_CUT_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    cut_hit |=> tail_q == $past(cut_tag)); // R8
  AST_CUT_KEEPS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    cut_req |=> $stable(head_q)); // R10
endmodule

// File: rtl/rename_map_unit.sv
module rename_map_unit #(
  parameter int unsigned NARCH = rmu_pkg::ARCH_REGS,
  parameter int unsigned NPHYS = rmu_pkg::PHYS_REGS,
  parameter int unsigned NWIN  = rmu_pkg::WIN_SLOTS,
  localparam int unsigned AW = $clog2(NARCH),
  localparam int unsigned PW = $clog2(NPHYS),
  localparam int unsigned WW = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  output logic          ren_ready,
  input  logic          ren_has_dst,
  input  logic [AW-1:0] ren_dst_arch,
  input  logic [AW-1:0] ren_src0_arch,
  input  logic [AW-1:0] ren_src1_arch,
  output logic [PW-1:0] ren_src0_phys,
  output logic [PW-1:0] ren_src1_phys,
  output logic [PW-1:0] ren_dst_phys,
  output logic [PW-1:0] ren_stale_phys,
  output logic [WW-1:0] ren_tag,
  input  logic          ret_valid,
  input  logic          sq_valid,
  input  logic [WW-1:0] sq_tag
);
  logic             win_full, win_empty, cut_hit, head_wr, any_free;
  logic [PW-1:0]    head_old;
  logic [NPHYS-1:0] cut_mask;
  logic             ren_fire, alloc_fire, ret_fire;

  assign ren_ready  = !sq_valid && !win_full && (any_free || !ren_has_dst);
  assign ren_fire   = ren_valid && ren_ready;
  assign alloc_fire = ren_fire && ren_has_dst;
  assign ret_fire   = ret_valid && !win_empty && !sq_valid;

  rmu_map #(.NARCH(NARCH), .NPHYS(NPHYS), .NWIN(NWIN)) u_map (
    .clk          (clk),
    .rst_n        (rst_n),
    .look0_arch   (ren_src0_arch),
    .look1_arch   (ren_src1_arch),
    .lookd_arch   (ren_dst_arch),
    .look0_phys   (ren_src0_phys),
    .look1_phys   (ren_src1_phys),
    .lookd_phys   (ren_stale_phys),
    .bind_en      (alloc_fire),
    .bind_arch    (ren_dst_arch),
    .bind_phys    (ren_dst_phys),
    .save_en      (ren_fire),
    .save_slot    (ren_tag),
    .restore_en   (cut_hit),
    .restore_slot (sq_tag)
  );

  rmu_free_list #(.NARCH(NARCH), .NPHYS(NPHYS)) u_free (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_en   (alloc_fire),
    .take_phys (ren_dst_phys),
    .any_free  (any_free),
    .give_en   (ret_fire && head_wr),
    .give_phys (head_old),
    .give_mask (cut_mask)
  );

  rmu_window #(.NPHYS(NPHYS), .NWIN(NWIN)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ren_fire),
    .push_wr   (ren_has_dst),
    .push_new  (ren_dst_phys),
    .push_old  (ren_stale_phys),
    .pop       (ret_fire),
    .cut_req   (sq_valid),
    .cut_tag   (sq_tag),
    .tail_slot (ren_tag),
    .full      (win_full),
    .empty     (win_empty),
    .cut_hit   (cut_hit),
    .head_wr   (head_wr),
    .head_old  (head_old),
    .cut_mask  (cut_mask)
  );

  AST_SQUASH_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |-> !ren_ready); // R6
  AST_ALLOC_NEW_REG: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> (ren_dst_phys != ren_stale_phys)); // R3
endmodule

// File: tb/sim_rename_map_unit.sv
`timescale 1ns/1ps
module sim_rename_map_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ren_valid, ren_has_dst, ret_valid, sq_valid;
  logic [4:0] ren_dst_arch, ren_src0_arch, ren_src1_arch;
  logic [3:0] sq_tag;
  logic       ren_ready;
  logic [5:0] ren_src0_phys, ren_src1_phys, ren_dst_phys, ren_stale_phys;
  logic [3:0] ren_tag;

  always #2 clk = ~clk;

  rename_map_unit u0 (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
    .ren_has_dst(ren_has_dst), .ren_dst_arch(ren_dst_arch),
    .ren_src0_arch(ren_src0_arch), .ren_src1_arch(ren_src1_arch),
    .ren_src0_phys(ren_src0_phys), .ren_src1_phys(ren_src1_phys),
    .ren_dst_phys(ren_dst_phys), .ren_stale_phys(ren_stale_phys),
    .ren_tag(ren_tag), .ret_valid(ret_valid), .sq_valid(sq_valid), .sq_tag(sq_tag)
  );

  typedef struct packed { int tag; logic wr; int nreg; int oreg; } ent_t;
  int   mmap [32];
  int   ckpt [16][32];
  bit   pool [64];
  ent_t win [$];
  int   tl;
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < 64; i++) if (pool[i]) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) mmap[i] = i;
    for (int i = 0; i < 64; i++) pool[i] = (i >= 32);
    win.delete();
    tl = 0;
  endtask

  // one cycle: drive, compare, clock, advance model
  task automatic cyc(bit rv, bit hd, int d, int s0, int s1, bit rt, bit sq, int st, string tagr);
    bit er, fire;
    int nd, k;
    @(negedge clk);
    ren_valid = rv; ren_has_dst = hd; ren_dst_arch = 5'(d);
    ren_src0_arch = 5'(s0); ren_src1_arch = 5'(s1);
    ret_valid = rt; sq_valid = sq; sq_tag = 4'(st);
    #1;
    nd = lowest_free();
    er = !sq && win.size() < 16 && (nd >= 0 || !hd);
    chk({"R6 ready ", tagr}, int'(ren_ready), int'(er));
    fire = rv && er;
    if (rv) begin
      chk({"R2 src0 ", tagr}, int'(ren_src0_phys), mmap[s0]);
      chk({"R2 src1 ", tagr}, int'(ren_src1_phys), mmap[s1]);
      chk({"R5 tag ", tagr}, int'(ren_tag), tl);
      if (hd) begin
        chk({"R3 dst ", tagr}, int'(ren_dst_phys), nd);
        chk({"R4 stale ", tagr}, int'(ren_stale_phys), mmap[d]);
      end
    end
    @(posedge clk);
    if (sq) begin
      k = -1;
      for (int i = 0; i < win.size(); i++) if (win[i].tag == st) k = i;
      if (k >= 0) begin
        for (int a = 0; a < 32; a++) mmap[a] = ckpt[st][a];
        while (win.size() > k) begin
          ent_t e = win.pop_back();
          if (e.wr) pool[e.nreg] = 1;
        end
        tl = st;
      end
    end else begin
      if (rt && win.size() > 0) begin
        ent_t e = win.pop_front();
        if (e.wr) pool[e.oreg] = 1;
      end
      if (fire) begin
        ent_t e;
        for (int a = 0; a < 32; a++) ckpt[tl][a] = mmap[a];
        e.tag = tl; e.wr = hd; e.nreg = nd; e.oreg = mmap[d];
        if (hd) begin pool[nd] = 0; mmap[d] = nd; end
        win.push_back(e);
        tl = (tl + 1) % 16;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int t;
    rst_n = 1'b0;
    ren_valid = 0; ren_has_dst = 0; ren_dst_arch = 0; ren_src0_arch = 0;
    ren_src1_arch = 0; ret_valid = 0; sq_valid = 0; sq_tag = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset map and free list
    ren_src0_arch = 5'd7; ren_src1_arch = 5'd31; ren_has_dst = 1;
    #1;
    chk("R1 ready", int'(ren_ready), 1);
    chk("R1 src0 identity", int'(ren_src0_phys), 7);
    chk("R1 src1 identity", int'(ren_src1_phys), 31);
    chk("R1 first free", int'(ren_dst_phys), 32);
    chk("R1 tag zero", int'(ren_tag), 0);
    // R2 own-dest source, R3 chain
    cyc(1, 1, 1, 1, 2, 0, 0, 0, "r2_self");
    cyc(1, 1, 3, 1, 3, 0, 0, 0, "r3_chain");
    cyc(1, 0, 4, 3, 1, 0, 0, 0, "r11_nodst");
    cyc(1, 1, 4, 4, 3, 0, 0, 0, "r3_after_nodst");
    // fill window (R6)
    for (int i = 0; i < 14; i++) cyc(1, 1, i % 8, i % 8, 1, 0, 0, 0, "r6_fill");
    cyc(1, 1, 9, 9, 9, 0, 0, 0, "r6_full_blocked");
    cyc(1, 1, 9, 9, 9, 1, 0, 0, "r7_retire_full");
    cyc(1, 1, 9, 9, 9, 1, 0, 0, "r7_rename_and_retire");
    // R10: squash with a tag not in flight is impossible while full; retire some first
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 1, 0, 0, "r7_drain");
    t = (tl + 3) % 16;
    cyc(1, 1, 2, 2, 2, 1, 1, t, "r10_stray_squash");
    cyc(1, 1, 2, 2, 2, 0, 0, 0, "r10_after");
    // R8/R9: squash the middle of the window
    for (int i = 0; i < 3; i++) cyc(1, 1, 5, 5, 6, 0, 0, 0, "r8_setup");
    t = (tl + 14) % 16;
    cyc(0, 0, 0, 0, 0, 0, 1, t, "r8_squash");
    cyc(1, 1, 5, 5, 6, 0, 0, 0, "r8_restored");
    cyc(1, 1, 6, 5, 1, 0, 0, 0, "r9_reuse");
    // drain fully, then retire on empty
    for (int i = 0; i < 18; i++) cyc(0, 0, 0, 0, 0, 1, 0, 0, "r7_drain_all");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, "r7_empty_retire");
    cyc(1, 1, 0, 0, 1, 0, 0, 0, "r7_after_empty");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 4) != 0, ($urandom % 5) != 0, $urandom % 32, $urandom % 32,
          $urandom % 32, ($urandom % 3) == 0, ($urandom % 30) == 0, $urandom % 16, "random");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule